// File: doc/BRIEF.md
# Oversampling Power-of-Two Averager

This block sits behind a multi-channel converter sequencer. Each time a frame of eight signed 16-bit conversion results arrives (marked by a one-cycle frame strobe), every channel's value is added into its own accumulator. A 3-bit oversampling code selects how many consecutive frames make up one averaging sequence: the ratio is two to the power of the code, from 1 up to 64. When the last frame of a sequence has been added, the block emits one frame of per-channel means and clears its accumulators. The output frame rate is therefore the input frame rate divided by the ratio.

A down-counter output reports how many conversions are still needed to close the current sequence. A sequencer can use it to hold its busy indication until the count reaches its final value. The code is sampled only when a sequence opens, so software may change it at any time without corrupting a partly built average.

The controller has two states. WAIT_FIRST means no sequence is open, and the live code defines the ratio. On a frame it goes to RUN, or it stays in WAIT_FIRST when the ratio is 1. RUN means a sequence is open with a latched code. On the last frame it returns to WAIT_FIRST; otherwise it stays in RUN.

Top module: `ovs_mean_avg`

## Requirements
- R1: With code 0 every input frame is passed straight through. Channel c occupies bits [16c+15:16c] of both data buses, and the result appears on `out_data` with `out_valid` high in the cycle after the frame strobe.
- R2: With code n from 1 to 6, exactly 2^n frames are accumulated per channel, and one output frame is produced after the last of them.
- R3: Each channel's mean is the exact sum of the sequence arithmetically shifted right by n, which rounds toward negative infinity. Full-scale sequences of 64 frames (all 32767 or all -32768) do not overflow.
- R4: Code 7 is unsupported and behaves exactly as code 0.
- R5: The code is sampled on the first frame of a sequence. A change during an open sequence does not alter that sequence's length or shift; it applies from the next sequence.
- R6: `conv_left` equals 2^code minus the number of frames accumulated in the open sequence. When no sequence is open it reflects the current input code.
- R7: `out_valid` is high for exactly one cycle, the cycle after the strobe of a sequence's last frame. Between results `out_data` holds its last value.
- R8: Cycles without a frame strobe do not advance the sequence or change any output.
- R9: After reset `out_valid` is 0, `out_data` is 0 and no sequence is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_code | input | 3 | Oversampling code, ratio 2^code (7 treated as 0) |
| in_valid | input | 1 | One-cycle strobe marking a valid input frame |
| in_data | input | 128 | Eight signed 16-bit conversion results, channel c at [16c+15:16c] |
| out_valid | output | 1 | One-cycle strobe marking a new mean frame |
| out_data | output | 128 | Eight signed 16-bit means, same channel layout |
| conv_left | output | 7 | Conversions still required to complete the sequence |

## Verification
The assertions assume that `in_valid` is a clean strobe that holds no X and that each asserted cycle carries one complete frame. They also assume that `os_code` is a defined value whenever a frame could open a sequence. The stimulus drives every input on the falling clock edge and keeps both inputs at known values from time zero. It changes the code only between frames, including in the middle of an open sequence, so that the latching rule is exercised under those assumptions.

// File: rtl/ovs_avg_pkg.sv
package ovs_avg_pkg;
    typedef enum logic {
        ST_WAIT_FIRST = 1'b0,
        ST_RUN        = 1'b1
    } seq_state_e;
endpackage

// File: rtl/ovs_seq_ctrl.sv
module ovs_seq_ctrl
    import ovs_avg_pkg::*;
#(
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 6,
    localparam int CNT_W   = MAX_CODE + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] os_code,
    input  logic              in_valid,
    output logic [CODE_W-1:0] shift_o,
    output logic              last_o,
    output logic [CNT_W-1:0]  remaining_o
);
    seq_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] eff_code;
    logic [CODE_W-1:0] cur_code;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  ratio;

    assign eff_code = (os_code > CODE_W'(MAX_CODE)) ? '0 : os_code;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_FIRST;
            code_q  <= '0;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                if (state_q == ST_WAIT_FIRST) code_q <= eff_code;
                count_q <= last_o ? '0 : count_q + CNT_W'(1);
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_FIRST: cur_code = eff_code;
            ST_RUN:        cur_code = code_q;
        endcase
        ratio       = CNT_W'(1) << cur_code;
        last_o      = in_valid && ((count_q + CNT_W'(1)) == ratio);
        remaining_o = ratio - count_q;
        shift_o     = cur_code;
        unique case (state_q)
            ST_WAIT_FIRST: if (in_valid && !last_o) state_d = ST_RUN;
            ST_RUN:        if (last_o) state_d = ST_WAIT_FIRST;
        endcase
    end

    // R6
    rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining_o != '0) && (remaining_o <= CNT_W'(1 << MAX_CODE)));

    // R6
    rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !last_o) |=> (remaining_o == $past(remaining_o) - CNT_W'(1)));

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !last_o) |=> $stable(code_q));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> ($stable(count_q) && $stable(state_q)));
endmodule

// File: rtl/ovs_avg_lane.sv
module ovs_avg_lane #(
    parameter int DATA_W   = 16,
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 6,
    localparam int ACC_W   = DATA_W + MAX_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              last,
    input  logic [CODE_W-1:0] shift,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] mean
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] scaled;

    assign sum    = acc_q + {{MAX_CODE{sample[DATA_W-1]}}, sample};
    assign scaled = sum >>> shift;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            mean  <= '0;
        end else if (in_valid) begin
            if (last) begin
                acc_q <= '0;
                mean  <= scaled[DATA_W-1:0];
            end else begin
                acc_q <= sum;
            end
        end
    end

    // R2
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && last) |=> (acc_q == '0));

    // R7
    mean_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && last) |=> $stable(mean));
endmodule

// File: rtl/ovs_mean_avg.sv
module ovs_mean_avg #(
    parameter int NUM_CH   = 8,
    parameter int DATA_W   = 16,
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 6,
    localparam int BUS_W   = NUM_CH * DATA_W,
    localparam int CNT_W   = MAX_CODE + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] os_code,
    input  logic              in_valid,
    input  logic [BUS_W-1:0]  in_data,
    output logic              out_valid,
    output logic [BUS_W-1:0]  out_data,
    output logic [CNT_W-1:0]  conv_left
);
    logic [CODE_W-1:0] shift;
    logic              last;

    ovs_seq_ctrl #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .os_code(os_code), .in_valid(in_valid),
        .shift_o(shift), .last_o(last), .remaining_o(conv_left)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        ovs_avg_lane #(.DATA_W(DATA_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) lane_i (
            .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .last(last),
            .shift(shift), .sample(in_data[c*DATA_W +: DATA_W]),
            .mean(out_data[c*DATA_W +: DATA_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= last;
    end

    // R7
    ovalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R7
    ovalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_valid, 1)) |=> !out_valid);
endmodule

// File: tb/ovs_mean_avg_tb_top.sv
module ovs_mean_avg_tb_top;
    typedef struct packed {
        logic [2:0]  code;
        logic [1:0]  mode;
        logic [15:0] seed;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 16'h1234}, '{3'd1, 2'd0, 16'h8001}, '{3'd2, 2'd0, 16'h7F00},
        '{3'd3, 2'd0, 16'h0F0F}, '{3'd4, 2'd0, 16'hC0DE}, '{3'd5, 2'd0, 16'h5A5A},
        '{3'd6, 2'd0, 16'h3333}, '{3'd6, 2'd1, 16'h0000}, '{3'd6, 2'd2, 16'h0000},
        '{3'd7, 2'd0, 16'hBEEF}, '{3'd3, 2'd2, 16'h0000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   os_code = '0;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic [127:0] out_data;
    logic [6:0]   conv_left;
    int           checks = 0;
    int           fails = 0;
    bit           done = 0;

    always #5 clk = ~clk;

    ovs_mean_avg dut_i (
        .clk(clk), .rst_n(rst_n), .os_code(os_code), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .conv_left(conv_left)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] smp(input vec_t v, input int c, input int k);
        case (v.mode)
            2'd1:    return 16'h7FFF;
            2'd2:    return 16'h8000;
            default: return 16'(int'(v.seed) + c * 4679 + k * (c + 3) * 911 + k * k * 37);
        endcase
    endfunction

    // one frame: drive at falling edge, return out_valid one cycle later
    task automatic push(input logic [127:0] d, output bit ov);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        ov = out_valid;
    endtask

    task automatic run_vec(input vec_t v, input string req);
        int     eff;
        int     ratio;
        longint sums [8];
        bit     ov;
        logic [127:0] d;
        os_code = v.code;
        #1;
        eff   = (v.code == 3'd7) ? 0 : int'(v.code);
        ratio = 1 << eff;
        foreach (sums[c]) sums[c] = 0;
        for (int k = 0; k < ratio; k++) begin
            chk(conv_left == 7'(ratio - k), "R6 conv_left", conv_left, ratio - k);
            for (int c = 0; c < 8; c++) begin
                d[c*16 +: 16] = smp(v, c, k);
                sums[c] += longint'($signed(smp(v, c, k)));
            end
            push(d, ov);
            chk(ov == (k == ratio - 1), {req, " R7 out_valid timing"}, ov, k == ratio - 1);
        end
        for (int c = 0; c < 8; c++) begin
            logic [15:0] e;
            e = 16'(sums[c] >>> eff);
            chk(out_data[c*16 +: 16] == e, {req, " R3 mean"}, out_data[c*16 +: 16], e);
        end
        d = out_data;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 single-cycle pulse", out_valid, 0);
        chk(out_data == d, "R7 out_data hold", out_data[15:0], d[15:0]);
    endtask

    function automatic logic [127:0] fill(input logic [15:0] x);
        return {8{x}};
    endfunction

    initial begin
        bit ov;
        logic [127:0] snap;
        // R9 reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
        chk(out_data == '0, "R9 out_data in reset", out_data[15:0], 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_left == 7'd1, "R9 no open sequence", conv_left, 1);
        chk(out_data == '0, "R9 out_data after reset", out_data[15:0], 0);

        // table walk: R1 (code 0), R2 (codes 1..6), R3 extremes, R4 (code 7)
        for (int i = 0; i < NV; i++) begin
            string tag;
            if (VECS[i].code == 3'd0)      tag = "R1";
            else if (VECS[i].code == 3'd7) tag = "R4";
            else                           tag = "R2";
            run_vec(VECS[i], tag);
        end

        // R3 rounding toward negative infinity
        os_code = 3'd1;
        push(fill(16'hFFFF), ov);
        push(fill(16'h0000), ov);
        chk(out_data[15:0] == 16'hFFFF, "R3 floor of -1/2", $signed(out_data[15:0]), -1);
        push(fill(16'h0001), ov);
        push(fill(16'h0000), ov);
        chk(out_data[15:0] == 16'h0000, "R3 floor of 1/2", out_data[15:0], 0);

        // R8 idle gaps inside a sequence
        os_code = 3'd2;
        push(fill(16'd10), ov);
        push(fill(16'd20), ov);
        snap = out_data;
        repeat (6) @(negedge clk);
        chk(conv_left == 7'd2, "R8 gap keeps count", conv_left, 2);
        chk(out_valid == 1'b0, "R8 gap no output", out_valid, 0);
        chk(out_data == snap, "R8 gap keeps data", out_data[15:0], snap[15:0]);
        push(fill(16'd30), ov);
        push(fill(16'd41), ov);
        chk(ov == 1'b1, "R8 completes after gap", ov, 1);
        chk(out_data[31:16] == 16'd25, "R8 mean after gap", out_data[31:16], 25);

        // R5 code change mid-sequence
        os_code = 3'd2;
        push(fill(16'd100), ov);
        os_code = 3'd5;
        #1;
        chk(conv_left == 7'd3, "R5 old code kept for count", conv_left, 3);
        push(fill(16'd200), ov);
        push(fill(16'd300), ov);
        chk(ov == 1'b0, "R5 no early output", ov, 0);
        push(fill(16'd404), ov);
        chk(ov == 1'b1, "R5 closes after four", ov, 1);
        chk(out_data[127:112] == 16'd251, "R5 old shift used", out_data[127:112], 251);
        chk(conv_left == 7'd32, "R5 new code next sequence", conv_left, 32);

        // R4 code 7 while idle reports ratio one
        os_code = 3'd7;
        #1;
        chk(conv_left == 7'd1, "R4 code 7 ratio", conv_left, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule